// File: doc/BRIEF.md
# Vector Length Configuration Unit

This block keeps the vector configuration of a packed-SIMD core whose vector registers live in the integer register file. A configuration write selects one of three element-type modes and the highest configured vector register. From the mode and the machine word width, the unit derives the maximum vector length (MVL). A set-length request writes the vector length register (VL) with the requested count, clipped to MVL. The clipped value is returned on a result port in the same cycle the request is offered.

The execution and memory units read VL and MVL from the unit. A per-register query reports the element type that the current configuration assigns to any register number. A memory-opcode port classifies vector memory operations. Plain loads and stores are told to move VL elements. Indexed and strided forms raise a trap request and move nothing, so that software can emulate them.

Top module: `vlcfg_unit`

## Requirements
- R1: After reset the mode is mixed-bank, the highest configured register is 29, VL reads 0 and MVL reads the mixed-bank value.
- R2: Mode code 0 (mixed banks) gives MVL = XLEN/16: 2 for a 32-bit word and 4 for a 64-bit word.
- R3: Mode code 1 (all 16-bit elements) gives the same MVL as mode code 0.
- R4: Mode code 2 (all 8-bit elements) gives MVL = XLEN/8: 4 for a 32-bit word and 8 for a 64-bit word.
- R5: A configuration write carrying mode code 3 is ignored as a whole. Mode, highest register, MVL and VL keep their values.
- R6: When setvl_valid is high, setvl_vl equals min(setvl_req, MVL) in that same cycle, and VL holds that value from the next clock edge. When setvl_valid and cfg_we are both low, VL does not change.
- R7: A legal configuration write changes MVL at the next clock edge. At that edge VL becomes min(VL, new MVL).
- R8: When a set-length request and a legal configuration write arrive in the same cycle, setvl_vl is clipped against the old MVL, and VL after the edge is min(setvl_vl, new MVL).
- R9: The type query returns code 2 (32-bit) for any register above the highest configured register, and the highest-register setting never changes MVL. At or below that register it returns code 0 (8-bit) or code 1 (16-bit). In mode 0, registers 0 to 15 give code 0 and higher registers give code 1. Mode 1 gives code 1 and mode 2 gives code 0.
- R10: With mem_valid high, the opcodes 3 (indexed load), 4 (indexed store), 5 (strided load) and 6 (strided store) drive mem_trap high and mem_elems to 0.
- R11: With mem_valid high, opcodes 1 (plain load) and 2 (plain store) keep mem_trap low and drive mem_elems to VL. Any other case drives both outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Element-type mode code for the write |
| cfg_top | input | RIDW (5) | Highest configured vector register for the write |
| setvl_valid | input | 1 | Set-length request |
| setvl_req | input | REQW (8) | Requested vector length |
| setvl_vl | output | VLW (4) | Granted length, same cycle |
| vl | output | VLW (4) | Current vector length |
| mvl | output | VLW (4) | Current maximum vector length |
| q_reg | input | RIDW (5) | Register number to classify |
| q_etype | output | 2 | Element type of q_reg: 0 8-bit, 1 16-bit, 2 32-bit |
| mem_valid | input | 1 | A vector memory opcode is presented |
| mem_op | input | 3 | Vector memory opcode class |
| mem_trap | output | 1 | Trap request for an unsupported form |
| mem_elems | output | VLW (4) | Elements the memory unit should transfer |

## Verification
A set-length request and a configuration write can meet in the same cycle. The result port then sees the old limit, while the VL register must respect the new one. The bench provokes this by first raising MVL to 8 with the 8-bit mode and then, in a single cycle, requesting 6 while switching back to mixed banks. It expects setvl_vl = 6 during that cycle, and VL = 4 and MVL = 4 after the edge. A second collision pairs a request with a reserved-mode write and expects the request to take full effect.

// File: rtl/vlcfg_pkg.sv
package vlcfg_pkg;

   typedef enum logic [1:0] {
      MODE_MIXED = 2'd0,
      MODE_ALL16 = 2'd1,
      MODE_ALL8  = 2'd2,
      MODE_RSVD  = 2'd3
   } mode_t;

   typedef enum logic [2:0] {
      MOP_NONE  = 3'd0,
      MOP_LD    = 3'd1,
      MOP_ST    = 3'd2,
      MOP_LDIDX = 3'd3,
      MOP_STIDX = 3'd4,
      MOP_LDSTR = 3'd5,
      MOP_STSTR = 3'd6,
      MOP_SPARE = 3'd7
   } memop_t;

   localparam logic [1:0] ET_B8  = 2'd0;
   localparam logic [1:0] ET_B16 = 2'd1;
   localparam logic [1:0] ET_B32 = 2'd2;

   localparam int MIXED_SPLIT = 16;

   function automatic logic mode_legal(input logic [1:0] code);
      return code != MODE_RSVD;
   endfunction

endpackage

// File: rtl/vlcfg_mvl_calc.sv
module vlcfg_mvl_calc
   import vlcfg_pkg::*;
#(
   parameter int XLEN = 64,
   parameter int VLW  = 4
) (
   input  logic [1:0]     mode,
   output logic [VLW-1:0] mvl
);

   localparam int NARROW = XLEN / 8;
   localparam int WIDE   = XLEN / 16;

   logic [VLW-1:0] narrow_v;
   logic [VLW-1:0] wide_v;

   generate
      if (XLEN == 64) begin : g_x64
         assign narrow_v = VLW'(8);
         assign wide_v   = VLW'(4);
      end else begin : g_x32
         assign narrow_v = VLW'(NARROW);
         assign wide_v   = VLW'(WIDE);
      end
   endgenerate

   always_comb begin
      case (mode_t'(mode))
         MODE_ALL8: mvl = narrow_v;
         default:   mvl = wide_v;
      endcase
   end

endmodule

// File: rtl/vlcfg_type_lookup.sv
module vlcfg_type_lookup
   import vlcfg_pkg::*;
#(
   parameter int RIDW = 5
) (
   input  logic [1:0]      mode,
   input  logic [RIDW-1:0] top,
   input  logic [RIDW-1:0] qreg,
   output logic [1:0]      etype
);

   logic low_bank;
   assign low_bank = int'(qreg) < MIXED_SPLIT;

   always_comb begin
      if (qreg > top) begin
         etype = ET_B32;
      end else begin
         case (mode_t'(mode))
            MODE_ALL8:  etype = ET_B8;
            MODE_ALL16: etype = ET_B16;
            default:    etype = low_bank ? ET_B8 : ET_B16;
         endcase
      end
   end

endmodule

// File: rtl/vlcfg_mem_filter.sv
module vlcfg_mem_filter
   import vlcfg_pkg::*;
#(
   parameter int VLW = 4
) (
   input  logic           valid,
   input  logic [2:0]     op,
   input  logic [VLW-1:0] vl,
   output logic           trap,
   output logic [VLW-1:0] elems
);

   always_comb begin
      trap  = 1'b0;
      elems = '0;
      if (valid) begin
         case (memop_t'(op))
            MOP_LD, MOP_ST: elems = vl;
            MOP_LDIDX, MOP_STIDX, MOP_LDSTR, MOP_STSTR: trap = 1'b1;
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/vlcfg_unit.sv
module vlcfg_unit
   import vlcfg_pkg::*;
#(
   parameter int XLEN    = 64,
   parameter int REQW    = 8,
   parameter int NREG    = 32,
   parameter int DEF_TOP = 29,
   localparam int RIDW   = $clog2(NREG),
   localparam int MAXMVL = XLEN / 8,
   localparam int VLW    = $clog2(MAXMVL + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_we,
   input  logic [1:0]      cfg_mode,
   input  logic [RIDW-1:0] cfg_top,
   input  logic            setvl_valid,
   input  logic [REQW-1:0] setvl_req,
   output logic [VLW-1:0]  setvl_vl,
   output logic [VLW-1:0]  vl,
   output logic [VLW-1:0]  mvl,
   input  logic [RIDW-1:0] q_reg,
   output logic [1:0]      q_etype,
   input  logic            mem_valid,
   input  logic [2:0]      mem_op,
   output logic            mem_trap,
   output logic [VLW-1:0]  mem_elems
);

   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("vlcfg_unit: XLEN must be 32 or 64");
      end
      if (REQW <= VLW) begin : g_bad_reqw
         $error("vlcfg_unit: REQW must exceed the VL width");
      end
      if (DEF_TOP >= NREG) begin : g_bad_top
         $error("vlcfg_unit: DEF_TOP out of register range");
      end
   endgenerate

   logic [1:0]      mode_q;
   logic [RIDW-1:0] top_q;
   logic [VLW-1:0]  vl_q;
   logic [VLW-1:0]  mvl_now;
   logic [VLW-1:0]  mvl_new;
   logic [VLW-1:0]  grant;
   logic [VLW-1:0]  vl_base;
   logic [VLW-1:0]  vl_next;
   logic            cfg_take;

   vlcfg_mvl_calc #(.XLEN(XLEN), .VLW(VLW)) u_mvl_now (
      .mode (mode_q),
      .mvl  (mvl_now)
   );

   vlcfg_mvl_calc #(.XLEN(XLEN), .VLW(VLW)) u_mvl_new (
      .mode (cfg_mode),
      .mvl  (mvl_new)
   );

   assign cfg_take = cfg_we && mode_legal(cfg_mode);

   always_comb begin
      if (setvl_req > {{(REQW-VLW){1'b0}}, mvl_now}) grant = mvl_now;
      else                                            grant = setvl_req[VLW-1:0];
   end

   assign vl_base = setvl_valid ? grant : vl_q;

   always_comb begin
      vl_next = vl_base;
      if (cfg_take && vl_base > mvl_new) vl_next = mvl_new;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= MODE_MIXED;
         top_q  <= RIDW'(DEF_TOP);
         vl_q   <= '0;
      end else begin
         vl_q <= vl_next;
         if (cfg_take) begin
            mode_q <= cfg_mode;
            top_q  <= cfg_top;
         end
      end
   end

   vlcfg_type_lookup #(.RIDW(RIDW)) u_type (
      .mode  (mode_q),
      .top   (top_q),
      .qreg  (q_reg),
      .etype (q_etype)
   );

   vlcfg_mem_filter #(.VLW(VLW)) u_mem (
      .valid (mem_valid),
      .op    (mem_op),
      .vl    (vl_q),
      .trap  (mem_trap),
      .elems (mem_elems)
   );

   assign setvl_vl = grant;
   assign vl       = vl_q;
   assign mvl      = mvl_now;

endmodule

// File: rtl/vlcfg_unit_chk.sv
module vlcfg_unit_chk #(
   parameter int REQW = 8,
   parameter int VLW  = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cfg_we,
   input logic [1:0]      cfg_mode,
   input logic            setvl_valid,
   input logic [REQW-1:0] setvl_req,
   input logic [VLW-1:0]  setvl_vl,
   input logic [VLW-1:0]  vl,
   input logic [VLW-1:0]  mvl,
   input logic            mem_valid,
   input logic [2:0]      mem_op,
   input logic            mem_trap,
   input logic [VLW-1:0]  mem_elems
);

   AST_VL_WITHIN_MVL: assert property (@(posedge clk) disable iff (!rst_n)
      vl <= mvl); // R7

   AST_GRANT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      setvl_valid |-> (setvl_vl <= mvl) && ({{(REQW-VLW){1'b0}}, setvl_vl} <= setvl_req)); // R6

   AST_GRANT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      setvl_valid && !cfg_we |=> vl == $past(setvl_vl)); // R6

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !setvl_valid && !cfg_we |=> $stable(vl) && $stable(mvl)); // R6

   AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we && cfg_mode == 2'd3 && !setvl_valid |=> $stable(mvl) && $stable(vl)); // R5

   AST_TRAP_NO_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      mem_trap |-> mem_valid && mem_elems == '0); // R10

   AST_PLAIN_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && (mem_op == 3'd1 || mem_op == 3'd2) |-> !mem_trap && mem_elems == vl); // R11

endmodule

bind vlcfg_unit vlcfg_unit_chk #(.REQW(REQW), .VLW(VLW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_we      (cfg_we),
   .cfg_mode    (cfg_mode),
   .setvl_valid (setvl_valid),
   .setvl_req   (setvl_req),
   .setvl_vl    (setvl_vl),
   .vl          (vl),
   .mvl         (mvl),
   .mem_valid   (mem_valid),
   .mem_op      (mem_op),
   .mem_trap    (mem_trap),
   .mem_elems   (mem_elems)
);

// File: tb/vlcfg_unit_test.sv
module vlcfg_unit_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [1:0] cfg_mode = 2'd0;
   logic [4:0] cfg_top = 5'd0;
   logic       setvl_valid = 1'b0;
   logic [7:0] setvl_req = 8'd0;
   logic [3:0] setvl_vl;
   logic [3:0] vl;
   logic [3:0] mvl;
   logic [4:0] q_reg = 5'd0;
   logic [1:0] q_etype;
   logic       mem_valid = 1'b0;
   logic [2:0] mem_op = 3'd0;
   logic       mem_trap;
   logic [3:0] mem_elems;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   vlcfg_unit uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_top(cfg_top),
      .setvl_valid(setvl_valid), .setvl_req(setvl_req), .setvl_vl(setvl_vl),
      .vl(vl), .mvl(mvl), .q_reg(q_reg), .q_etype(q_etype),
      .mem_valid(mem_valid), .mem_op(mem_op), .mem_trap(mem_trap), .mem_elems(mem_elems)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   task automatic qtype(input int r, input int exp, input string tag);
      q_reg = 5'(r);
      #1 chk(tag, int'(q_etype), exp);
   endtask

   // drive one cycle of config write and/or setvl; check grant and post-edge state
   task automatic cycle(input bit we, input int mode, input int top,
                        input bit sv, input int req,
                        input int exp_grant, input int exp_vl, input int exp_mvl,
                        input string tag);
      @(negedge clk);
      cfg_we = we; cfg_mode = 2'(mode); cfg_top = 5'(top);
      setvl_valid = sv; setvl_req = 8'(req);
      #1 if (sv) chk({tag, " grant"}, int'(setvl_vl), exp_grant);
      @(negedge clk);
      cfg_we = 1'b0; setvl_valid = 1'b0;
      #1 chk({tag, " vl"}, int'(vl), exp_vl);
      chk({tag, " mvl"}, int'(mvl), exp_mvl);
   endtask

   task automatic test_reset();
      #1 chk("R1 vl", int'(vl), 0);
      chk("R1 mvl", int'(mvl), 4);
      qtype(29, 1, "R1 top reg29");
      qtype(30, 2, "R1 top reg30");
      qtype(3, 0, "R1 reg3");
   endtask

   task automatic test_setvl();
      cycle(0, 0, 0, 1, 3, 3, 3, 4, "R6 req3");
      cycle(0, 0, 0, 1, 200, 4, 4, 4, "R6 req200");
      cycle(0, 0, 0, 0, 1, 0, 4, 4, "R6 idle");
      cycle(0, 0, 0, 1, 0, 0, 0, 4, "R6 req0");
      cycle(0, 0, 0, 1, 4, 4, 4, 4, "R2 req=mvl");
   endtask

   task automatic test_modes();
      cycle(1, 2, 29, 0, 0, 0, 4, 8, "R4 all8");
      cycle(0, 0, 0, 1, 7, 7, 7, 8, "R4 req7");
      cycle(0, 0, 0, 1, 9, 8, 8, 8, "R4 req9");
      cycle(1, 1, 29, 0, 0, 0, 4, 4, "R7 clamp to all16");
      cycle(0, 0, 0, 1, 9, 4, 4, 4, "R3 req9");
      cycle(1, 0, 29, 0, 0, 0, 4, 4, "R2 back to mixed");
   endtask

   task automatic test_reserved();
      cycle(1, 2, 29, 0, 0, 0, 4, 8, "R5 prep");
      cycle(0, 0, 0, 1, 6, 6, 6, 8, "R5 prep vl");
      cycle(1, 3, 5, 0, 0, 0, 6, 8, "R5 rsvd write");
      qtype(10, 0, "R5 top unchanged");
      cycle(1, 3, 5, 1, 2, 2, 2, 8, "R5 rsvd with setvl");
   endtask

   task automatic test_collision();
      cycle(1, 0, 29, 1, 6, 6, 4, 4, "R8 collide");
      cycle(1, 2, 29, 1, 3, 3, 3, 8, "R8 grow collide");
   endtask

   task automatic test_types();
      cycle(1, 0, 20, 0, 0, 0, 3, 4, "R9 top20 mvl");
      qtype(20, 1, "R9 reg20");
      qtype(21, 2, "R9 reg21");
      qtype(15, 0, "R9 reg15");
      qtype(16, 1, "R9 reg16");
      cycle(1, 1, 20, 0, 0, 0, 3, 4, "R9 all16");
      qtype(3, 1, "R9 all16 reg3");
      cycle(1, 2, 31, 0, 0, 0, 3, 8, "R9 all8");
      qtype(18, 0, "R9 all8 reg18");
      qtype(31, 0, "R9 all8 reg31");
   endtask

   task automatic test_mem();
      @(negedge clk);
      mem_valid = 1'b1;
      for (int op = 0; op < 8; op++) begin
         mem_op = 3'(op);
         #1;
         if (op >= 3 && op <= 6) begin
            chk($sformatf("R10 op%0d trap", op), int'(mem_trap), 1);
            chk($sformatf("R10 op%0d elems", op), int'(mem_elems), 0);
         end else if (op == 1 || op == 2) begin
            chk($sformatf("R11 op%0d trap", op), int'(mem_trap), 0);
            chk($sformatf("R11 op%0d elems", op), int'(mem_elems), 3);
         end else begin
            chk($sformatf("R11 op%0d trap", op), int'(mem_trap), 0);
            chk($sformatf("R11 op%0d elems", op), int'(mem_elems), 0);
         end
      end
      mem_op = 3'd4;
      mem_valid = 1'b0;
      #1 chk("R10 no valid trap", int'(mem_trap), 0);
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      test_reset();
      test_setvl();
      test_modes();
      test_reserved();
      test_collision();
      test_types();
      test_mem();
      repeat (2) @(negedge clk);
      summary();
   end

endmodule